// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a single-channel digital-to-analog converter. It takes a three-wire serial write: an active-low frame select, a serial clock and one data line. All three are brought into the system clock domain by oversampling. While the frame select is low, the block shifts in one bit on each falling serial-clock edge. A complete frame is committed to a code register and a two-bit power-down mode register.

The frame length is a build-time choice. A 16-bit frame carries a 14-bit code. A 24-bit frame carries a 16-bit code followed by six unused bits. In both formats the two mode bits come first, then the code MSB-first. If the frame select returns high before the last falling edge of a frame, the whole write is dropped. Once a frame is complete, further clock edges do nothing until the select goes high and then low again. Each commit raises a one-cycle strobe in the system clock domain.

Top module: `dac_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, the code, the mode bits and the strobe are all zero until the first complete frame.
- R2: After a complete frame, the code output holds the code field. That field is the bits that follow the two mode bits, taken MSB-first: 14 bits for a 16-bit frame, 16 bits for a 24-bit frame.
- R3: After a complete frame, the mode output holds the first two bits of the frame, with the first bit sent becoming bit 1.
- R4: If the frame select rises before the final falling edge of a frame, the code and the mode outputs keep their previous values and no strobe is raised.
- R5: Each committed frame raises the update strobe for exactly one system clock cycle, and only once.
- R6: Falling edges after the final bit of a frame are ignored until the frame select goes high and then low again.
- R7: In a 24-bit frame, the last six bits have no effect on any output.
- R8: The code and the mode outputs change only in the cycle in which the update strobe is high.
- R9: The committed values appear at the outputs no later than four system clock cycles after the final falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock; data are taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data, MSB first |
| code | output | CODE_BITS | Committed DAC code (14 bits for a 16-bit frame, 16 bits for a 24-bit frame) |
| pd_mode | output | 2 | Committed power-down mode |
| upd | output | 1 | One-cycle strobe on each commit |

## Verification
A bit counter that is off by one either commits a frame that was aborted on its last edge or never commits a full frame. Either fault shows at the code and strobe outputs within four system cycles of that edge. A misaligned shift register puts the wrong bits in the mode and code fields, which is visible in the first frame committed after the fault. A select-edge detector that fails to rearm shows up as a stuck code from the second frame onward.

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int FRAME_BITS = 24,
  localparam int CODE_BITS = (FRAME_BITS == 16) ? 14 : 16,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 sync_n,
  input  logic                 sdi,
  output logic [CODE_BITS-1:0] code,
  output logic [1:0]           pd_mode,
  output logic                 upd
);

  logic [2:0]            sclk_q;
  logic [1:0]            sync_q;
  logic [1:0]            sdi_q;
  logic                  sync_d;
  logic                  armed;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-2:0] shreg;

  wire sclk_fall   = sclk_q[2] & ~sclk_q[1];
  wire sync_low    = ~sync_q[1];
  wire frame_start = sync_d & sync_low;
  wire [FRAME_BITS-1:0] frame = {shreg, sdi_q[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '1;
      sync_q <= '1;
      sync_d <= 1'b1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      sync_q <= {sync_q[0], sync_n};
      sync_d <= sync_q[1];
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      code    <= '0;
      pd_mode <= '0;
      upd     <= 1'b0;
    end else begin
      upd <= 1'b0;
      if (!sync_low) begin
        armed <= 1'b0;
      end else if (frame_start) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && sclk_fall) begin
        shreg <= frame[FRAME_BITS-2:0];
        cnt   <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(FRAME_BITS - 1)) begin
          armed   <= 1'b0;
          pd_mode <= frame[FRAME_BITS-1 -: 2];
          code    <= frame[FRAME_BITS-3 -: CODE_BITS];
          upd     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dac_frame_rx_chk.sv
module dac_frame_rx_chk #(
  parameter int CODE_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_n,
  input logic [CODE_BITS-1:0] code,
  input logic [1:0]           pd_mode,
  input logic                 upd
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (code == '0 && pd_mode == 2'b00 && !upd));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> ($stable(code) && $stable(pd_mode)));

  p_no_commit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> !$past(sync_n, 3));

endmodule

bind dac_frame_rx dac_frame_rx_chk #(.CODE_BITS(CODE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
  .code(code), .pd_mode(pd_mode), .upd(upd)
);

// File: tb/test_dac_frame_rx.sv
module test_dac_frame_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0;
  logic [15:0] code24;
  logic [13:0] code16;
  logic [1:0]  pd24, pd16;
  logic        upd24, upd16;
  int compared = 0, mismatched = 0;
  int n24 = 0, n16 = 0, dbl = 0;
  logic p24 = 1'b0, p16 = 1'b0;
  logic [15:0] e_code24 = '0;
  logic [13:0] e_code16 = '0;
  logic [1:0]  e_pd24 = '0, e_pd16 = '0;
  int e_n24 = 0, e_n16 = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dac_frame_rx #(.FRAME_BITS(24)) i_dac_frame_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .code(code24), .pd_mode(pd24), .upd(upd24));

  dac_frame_rx #(.FRAME_BITS(16)) i_dac_frame_rx_16 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .code(code16), .pd_mode(pd16), .upd(upd16));

  always @(negedge clk) begin
    if (upd24) n24++;
    if (upd16) n16++;
    if ((upd24 && p24) || (upd16 && p16)) dbl++;
    p24 = upd24;
    p16 = upd16;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] d, int edges);
    sync_n = 1'b0;
    tick(4);
    for (int i = 0; i < edges; i++) begin
      sclk = 1'b1;
      sdi = d[31-i];
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    if (edges >= 24) begin
      e_pd24 = d[31:30]; e_code24 = d[29:14]; e_n24++;
    end
    if (edges >= 16) begin
      e_pd16 = d[31:30]; e_code16 = d[29:16]; e_n16++;
    end
    chk("R2/R7 code24 (R9 latency)", 32'(code24), 32'(e_code24));
    chk("R3 pd24", 32'(pd24), 32'(e_pd24));
    chk("R2 code16 (R6 extra edges)", 32'(code16), 32'(e_code16));
    chk("R3 pd16", 32'(pd16), 32'(e_pd16));
    tick(4);
    sync_n = 1'b1;
    sclk = 1'b1;
    tick(8);
    chk("R4/R5 strobe count 24", n24, e_n24);
    chk("R4/R5 strobe count 16", n16, e_n16);
  endtask

  initial begin
    tick(6);
    chk("R1 reset code24", 32'(code24), 0);
    chk("R1 reset pd24", 32'(pd24), 0);
    chk("R1 reset upd", 32'({upd24, upd16}), 0);
    rst_n = 1'b1;
    tick(6);
    chk("R1 after release code16", 32'(code16), 0);
    for (int n = 0; n < 24; n++)
      send({2'b11, 16'hFFFF, 14'h3FFF}, n);
    for (int i = 0; i < 48; i++) begin
      logic [15:0] c;
      logic [13:0] lo;
      c = (i < 16) ? 16'(1 << i) : (i < 32) ? ~16'(1 << (i - 16))
                                            : 16'(i * 16'h9e37) ^ 16'h5a5a;
      lo = 14'(i * 14'h1357);
      send({2'(i % 4), c, lo}, 24 + (i % 9));
    end
    send({2'b01, 16'h1234, 14'h0}, 23);
    send({2'b10, 16'hBEEF, 14'h3FFF}, 24);
    send({2'b00, 16'h0000, 14'h2AAA}, 24);
    chk("R5 single-cycle strobe", dbl, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule